// File: doc/BRIEF.md
# Saturating Up/Down Counter Field

This block is one counting field of a register bank. Hardware raises the count with an up strobe and lowers it with a down strobe. Software loads the count through a write-enable and data pair, and reads it back from the `count` output. Each direction has its own step, its own optional clamp limit and its own threshold. A step is either fixed at one or taken each cycle from a step input, chosen per direction by a parameter.

If a clamp is turned off in a direction, the count wraps modulo 2^COUNT_W in that direction. The wrap raises a one-cycle overflow or underflow pulse. Two threshold flags follow the stored count: one for "at or above the up threshold" and one for "at or below the down threshold". A surrounding register block decodes the address and routes these signals. Its interrupt logic consumes the flags and pulses.

Top module: `updn_count_field`

## Requirements
- R1: An up strobe alone adds the up step to the count. A down strobe alone subtracts the down step. The new value appears on `count` after the next rising clock edge.
- R2: When both strobes are high in one cycle, the count changes by (up step minus down step) in a single update.
- R3: With a direction's external-step parameter at 0, that direction's step is 1 and its step input has no effect on the count.
- R4: With a direction's external-step parameter at 1, that direction's step is the value on its step input in that cycle, zero included.
- R5: With up clamping on, a net-positive update that would end above UP_CEIL leaves the count exactly at UP_CEIL. UP_CEIL defaults to all ones.
- R6: With down clamping on, a net-negative update that would end below DN_FLOOR leaves the count exactly at DN_FLOOR. DN_FLOOR defaults to zero.
- R7: With up clamping off, an update whose true sum exceeds 2^COUNT_W-1 stores the sum modulo 2^COUNT_W. It raises `overflow_pulse` for exactly the one cycle after that edge.
- R8: With down clamping off, an update whose true sum is below zero stores the sum modulo 2^COUNT_W. It raises `underflow_pulse` for exactly the one cycle after that edge.
- R9: `up_thresh_hit` is high whenever count >= UP_THRESH. UP_THRESH defaults to all ones.
- R10: `dn_thresh_hit` is high whenever count <= DN_THRESH. DN_THRESH defaults to zero.
- R11: A software write loads `sw_wr_data` and overrides any strobe update in that cycle. It raises neither pulse.
- R12: A synchronous active-low reset sets the count to zero and clears both pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_stb | input | 1 | Up strobe for the count |
| dn_stb | input | 1 | Down strobe for the count |
| up_step | input | COUNT_W | Up step when the external up step is enabled |
| dn_step | input | COUNT_W | Down step when the external down step is enabled |
| sw_wr_en | input | 1 | Software write enable |
| sw_wr_data | input | COUNT_W | Value loaded by a software write |
| count | output | COUNT_W | Stored count, the software read value |
| up_thresh_hit | output | 1 | Count at or above the up threshold |
| dn_thresh_hit | output | 1 | Count at or below the down threshold |
| overflow_pulse | output | 1 | One-cycle pulse after an upward wrap |
| underflow_pulse | output | 1 | One-cycle pulse after a downward wrap |

## Verification
Two 4-bit instances are swept over every start value, strobe pairing and step pair. One has external steps and both clamps on. The other has fixed steps and wraps in both directions. The sweep covers starts loaded above the ceiling or below the floor. A design that clamps whenever the count is outside the limits, rather than only on net moves, returns such a count to the limit on a step toward it. The sweep also covers opposing strobes whose steps cancel or nearly cancel. A design that applies the two strobes in sequence rather than as one net change would clamp or pulse on an update that never leaves the range. Pulses are checked both on the cycle after a wrap and on the cycle after that, which catches a pulse that sticks high. Software writes are issued together with both strobes, which catches a design that lets hardware win.

// File: rtl/ucf_pkg.sv
// Shared types for the up/down counter field.
// Assumes nothing beyond a single clock domain.
package ucf_pkg;

    // Outcome class of one next-state computation
    typedef enum logic [2:0] {
        NXT_PLAIN    = 3'd0,
        NXT_CLAMP_HI = 3'd1,
        NXT_CLAMP_LO = 3'd2,
        NXT_OVF      = 3'd3,
        NXT_UNF      = 3'd4
    } nxt_kind_e;

endpackage

// File: rtl/ucf_step_sel.sv
// Step selector for one counting direction.
// Gives the step applied this cycle: zero when the strobe is low, otherwise
// either a fixed step of one or the external step input, picked by EXT_STEP.
// Assumes the external step is stable for the cycle in which the strobe is high.
module ucf_step_sel #(
    parameter int COUNT_W  = 8,
    parameter bit EXT_STEP = 1'b0
) (
    input  logic               stb,
    input  logic [COUNT_W-1:0] ext_step,
    output logic [COUNT_W-1:0] step_eff
);

    logic [COUNT_W-1:0] step_raw;

    generate
        if (EXT_STEP) begin : g_ext
            assign step_raw = ext_step;
        end else begin : g_fixed
            logic unused_ext;
            assign unused_ext = ^ext_step;
            assign step_raw   = COUNT_W'(1);
        end
    endgenerate

    // Gate the step with its strobe
    always_comb begin
        step_eff = stb ? step_raw : '0;
    end

endmodule

// File: rtl/ucf_next_calc.sv
// Next-state arithmetic for the counter.
// Forms the net change as one signed sum and classifies the result:
// clamp at the ceiling for a net rise past UP_CEIL (if enabled), clamp at
// the floor for a net fall past DN_FLOOR (if enabled), otherwise wrap and
// report an upward or downward wrap.
// Assumes step inputs are already gated by their strobes.
module ucf_next_calc
    import ucf_pkg::*;
#(
    parameter int               COUNT_W   = 8,
    parameter bit               UP_SAT_EN = 1'b0,
    parameter logic [COUNT_W-1:0] UP_CEIL = '1,
    parameter bit               DN_SAT_EN = 1'b0,
    parameter logic [COUNT_W-1:0] DN_FLOOR = '0
) (
    input  logic [COUNT_W-1:0] cur,
    input  logic [COUNT_W-1:0] up_amt,
    input  logic [COUNT_W-1:0] dn_amt,
    output logic [COUNT_W-1:0] nxt,
    output nxt_kind_e          kind
);

    localparam int SUM_W = COUNT_W + 2;
    localparam logic signed [SUM_W-1:0] CEIL_S  = signed'({2'b00, UP_CEIL});
    localparam logic signed [SUM_W-1:0] FLOOR_S = signed'({2'b00, DN_FLOOR});

    logic signed [SUM_W-1:0] net_s;
    logic signed [SUM_W-1:0] sum_s;
    logic                    net_pos;
    logic                    net_neg;

    // Net change and raw sum, wide enough for both extremes
    always_comb begin
        net_s   = signed'({2'b00, up_amt}) - signed'({2'b00, dn_amt});
        sum_s   = signed'({2'b00, cur}) + net_s;
        net_neg = net_s[SUM_W-1];
        net_pos = !net_s[SUM_W-1] && (net_s != '0);
    end

    // Classify the sum and pick the stored value
    always_comb begin
        kind = NXT_PLAIN;
        nxt  = sum_s[COUNT_W-1:0];
        if (UP_SAT_EN && net_pos && (sum_s > CEIL_S)) begin
            kind = NXT_CLAMP_HI;
            nxt  = UP_CEIL;
        end else if (DN_SAT_EN && net_neg && (sum_s < FLOOR_S)) begin
            kind = NXT_CLAMP_LO;
            nxt  = DN_FLOOR;
        end else if (sum_s[SUM_W-1]) begin
            kind = NXT_UNF;
        end else if (sum_s[COUNT_W]) begin
            kind = NXT_OVF;
        end
    end

endmodule

// File: rtl/ucf_thresh_cmp.sv
// Threshold comparators on the stored count.
// Up flag: count at or above UP_THRESH. Down flag: count at or below DN_THRESH.
// Assumes the count input comes straight from the field storage register.
module ucf_thresh_cmp #(
    parameter int                 COUNT_W   = 8,
    parameter logic [COUNT_W-1:0] UP_THRESH = '1,
    parameter logic [COUNT_W-1:0] DN_THRESH = '0
) (
    input  logic [COUNT_W-1:0] count,
    output logic               up_hit,
    output logic               dn_hit
);

    // Compare the stored count against both thresholds
    always_comb begin
        up_hit = (count >= UP_THRESH);
        dn_hit = (count <= DN_THRESH);
    end

endmodule

// File: rtl/updn_count_field.sv
// Up/down counter register field.
// Holds the count, applies strobe updates through the next-state logic,
// lets a software write override them, and registers the wrap pulses.
// Assumes one clock and a synchronous active-low reset.
module updn_count_field
    import ucf_pkg::*;
#(
    parameter int                 COUNT_W     = 8,
    parameter bit                 UP_STEP_EXT = 1'b0,
    parameter bit                 DN_STEP_EXT = 1'b0,
    parameter bit                 UP_SAT_EN   = 1'b0,
    parameter logic [COUNT_W-1:0] UP_CEIL     = '1,
    parameter bit                 DN_SAT_EN   = 1'b0,
    parameter logic [COUNT_W-1:0] DN_FLOOR    = '0,
    parameter logic [COUNT_W-1:0] UP_THRESH   = '1,
    parameter logic [COUNT_W-1:0] DN_THRESH   = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               up_stb,
    input  logic               dn_stb,
    input  logic [COUNT_W-1:0] up_step,
    input  logic [COUNT_W-1:0] dn_step,
    input  logic               sw_wr_en,
    input  logic [COUNT_W-1:0] sw_wr_data,
    output logic [COUNT_W-1:0] count,
    output logic               up_thresh_hit,
    output logic               dn_thresh_hit,
    output logic               overflow_pulse,
    output logic               underflow_pulse
);

    logic [COUNT_W-1:0] up_amt;
    logic [COUNT_W-1:0] dn_amt;
    logic [COUNT_W-1:0] nxt;
    nxt_kind_e          kind;

    ucf_step_sel #(.COUNT_W(COUNT_W), .EXT_STEP(UP_STEP_EXT)) u_up_step (
        .stb(up_stb), .ext_step(up_step), .step_eff(up_amt)
    );

    ucf_step_sel #(.COUNT_W(COUNT_W), .EXT_STEP(DN_STEP_EXT)) u_dn_step (
        .stb(dn_stb), .ext_step(dn_step), .step_eff(dn_amt)
    );

    ucf_next_calc #(
        .COUNT_W(COUNT_W), .UP_SAT_EN(UP_SAT_EN), .UP_CEIL(UP_CEIL),
        .DN_SAT_EN(DN_SAT_EN), .DN_FLOOR(DN_FLOOR)
    ) u_calc (
        .cur(count), .up_amt(up_amt), .dn_amt(dn_amt), .nxt(nxt), .kind(kind)
    );

    ucf_thresh_cmp #(
        .COUNT_W(COUNT_W), .UP_THRESH(UP_THRESH), .DN_THRESH(DN_THRESH)
    ) u_thresh (
        .count(count), .up_hit(up_thresh_hit), .dn_hit(dn_thresh_hit)
    );

    // Field storage and wrap-event registers; software write has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count           <= '0;
            overflow_pulse  <= 1'b0;
            underflow_pulse <= 1'b0;
        end else if (sw_wr_en) begin
            count           <= sw_wr_data;
            overflow_pulse  <= 1'b0;
            underflow_pulse <= 1'b0;
        end else begin
            count           <= nxt;
            overflow_pulse  <= (kind == NXT_OVF);
            underflow_pulse <= (kind == NXT_UNF);
        end
    end

    // R11: a software write lands on the next edge, regardless of strobes
    assert_sw_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |=> (count == $past(sw_wr_data)));

    // R11: no wrap pulse follows a software write
    assert_sw_no_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |=> (!overflow_pulse && !underflow_pulse));

    // R1: with no strobe and no write, the count holds and no pulse appears
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_stb && !dn_stb && !sw_wr_en) |=>
            ($stable(count) && !overflow_pulse && !underflow_pulse));

    // R7: an upward wrap always leaves the count below where it was
    assert_ovf_wraps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_pulse |-> (count < $past(count)));

    // R8: a downward wrap always leaves the count above where it was
    assert_unf_wraps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_pulse |-> (count > $past(count)));

    // R7: the two wrap pulses never coincide
    assert_pulse_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow_pulse && underflow_pulse));

endmodule

// File: tb/updn_count_field_tb_top.sv
// Sweep bench: two 4-bit instances, one clamping with external steps, one
// wrapping with fixed steps. Expected values are computed arithmetically.
module updn_count_field_tb_top;

    localparam int W     = 4;
    localparam int MODV  = 16;
    localparam int CEIL  = 12;
    localparam int FLOOR = 3;
    localparam int UTH   = 10;
    localparam int DTH   = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         up_stb = 1'b0;
    logic         dn_stb = 1'b0;
    logic [W-1:0] up_step = '0;
    logic [W-1:0] dn_step = '0;
    logic         sw_wr_en = 1'b0;
    logic [W-1:0] sw_wr_data = '0;

    logic [W-1:0] cnt_a, cnt_b;
    logic         uh_a, dh_a, ov_a, un_a;
    logic         uh_b, dh_b, ov_b, un_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    updn_count_field #(
        .COUNT_W(W), .UP_STEP_EXT(1'b1), .DN_STEP_EXT(1'b1),
        .UP_SAT_EN(1'b1), .UP_CEIL(4'(CEIL)), .DN_SAT_EN(1'b1), .DN_FLOOR(4'(FLOOR)),
        .UP_THRESH(4'(UTH)), .DN_THRESH(4'(DTH))
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .up_stb(up_stb), .dn_stb(dn_stb),
        .up_step(up_step), .dn_step(dn_step), .sw_wr_en(sw_wr_en),
        .sw_wr_data(sw_wr_data), .count(cnt_a), .up_thresh_hit(uh_a),
        .dn_thresh_hit(dh_a), .overflow_pulse(ov_a), .underflow_pulse(un_a)
    );

    updn_count_field #(.COUNT_W(W)) dut_wrap_i (
        .clk(clk), .rst_n(rst_n), .up_stb(up_stb), .dn_stb(dn_stb),
        .up_step(up_step), .dn_step(dn_step), .sw_wr_en(sw_wr_en),
        .sw_wr_data(sw_wr_data), .count(cnt_b), .up_thresh_hit(uh_b),
        .dn_thresh_hit(dh_b), .overflow_pulse(ov_b), .underflow_pulse(un_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Arithmetic model of one update
    task automatic model(input int cur, input int us, input int ds,
                         input bit sat_u, input bit sat_d, input int ceil_v,
                         input int floor_v, output int nxt, output bit ovf,
                         output bit unf, output string tag);
        int net;
        int sum;
        net = us - ds;
        sum = cur + net;
        ovf = 1'b0;
        unf = 1'b0;
        tag = "R1";
        if (sat_u && net > 0 && sum > ceil_v) begin
            nxt = ceil_v; tag = "R5";
        end else if (sat_d && net < 0 && sum < floor_v) begin
            nxt = floor_v; tag = "R6";
        end else if (sum < 0) begin
            nxt = sum + MODV; unf = 1'b1; tag = "R8";
        end else if (sum >= MODV) begin
            nxt = sum - MODV; ovf = 1'b1; tag = "R7";
        end else begin
            nxt = sum;
        end
    endtask

    task automatic run_case(input int st, input bit ui, input bit di,
                            input int us, input int ds);
        int  ea, eb;
        bit  oa, ua, ob, ub;
        string ta, tb;
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_data = W'(st); up_stb = 1'b0; dn_stb = 1'b0;
        @(negedge clk);
        sw_wr_en = 1'b0; up_stb = ui; dn_stb = di;
        up_step = W'(us); dn_step = W'(ds);
        model(st, ui ? us : 0, di ? ds : 0, 1'b1, 1'b1, CEIL, FLOOR, ea, oa, ua, ta);
        model(st, ui ? 1 : 0, di ? 1 : 0, 1'b0, 1'b0, MODV - 1, 0, eb, ob, ub, tb);
        if (ta == "R1") ta = (ui && di) ? "R2" : "R4";
        if (tb == "R1") tb = (ui && di) ? "R2" : "R3";
        @(negedge clk);
        chk(ta, int'(cnt_a), ea);
        chk("R7 clamp instance ovf", int'(ov_a), int'(oa));
        chk("R8 clamp instance unf", int'(un_a), int'(ua));
        chk("R9", int'(uh_a), int'(ea >= UTH));
        chk("R10", int'(dh_a), int'(ea <= DTH));
        chk(tb, int'(cnt_b), eb);
        chk("R7", int'(ov_b), int'(ob));
        chk("R8", int'(un_b), int'(ub));
        chk("R9 default", int'(uh_b), int'(eb == MODV - 1));
        chk("R10 default", int'(dh_b), int'(eb == 0));
        up_stb = 1'b0; dn_stb = 1'b0;
        @(negedge clk);
        chk("R7 one-cycle", int'(ov_b), 0);
        chk("R8 one-cycle", int'(un_b), 0);
        chk("R1 hold", int'(cnt_b), eb);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 count", int'(cnt_a), 0);
        chk("R12 ovf", int'(ov_b), 0);
        chk("R12 unf", int'(un_b), 0);
        chk("R10 at reset", int'(dh_a), 1);
        chk("R9 at reset", int'(uh_a), 0);
        rst_n = 1'b1;

        for (int st = 0; st < MODV; st++)
            for (int m = 0; m < 4; m++)
                for (int us = 0; us < MODV; us++)
                    for (int ds = 0; ds < MODV; ds++)
                        run_case(st, m[0], m[1], us, ds);

        // R11: software write beats both strobes
        for (int st = 0; st < MODV; st++) begin
            for (int v = 0; v < MODV; v++) begin
                @(negedge clk);
                sw_wr_en = 1'b1; sw_wr_data = W'(st);
                @(negedge clk);
                sw_wr_en = 1'b1; sw_wr_data = W'(v);
                up_stb = 1'b1; dn_stb = 1'b1;
                up_step = W'(MODV - 1); dn_step = 4'd1;
                @(negedge clk);
                chk("R11 load", int'(cnt_a), v);
                chk("R11 load wrap", int'(cnt_b), v);
                chk("R11 no ovf", int'(ov_b), 0);
                chk("R11 no unf", int'(un_b), 0);
                sw_wr_en = 1'b0; up_stb = 1'b0; dn_stb = 1'b0;
            end
        end

        // R12: synchronous reset mid-run
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_data = 4'd9;
        @(negedge clk);
        sw_wr_en = 1'b0; rst_n = 1'b0; up_stb = 1'b1;
        @(negedge clk);
        chk("R12 mid-run count", int'(cnt_a), 0);
        chk("R12 mid-run wrap count", int'(cnt_b), 0);
        up_stb = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule